// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block sits on the host side of a three-wire link to a delta-sigma converter. The converter uses its data-out line as a ready flag. The block drives chip select low and waits for that line to drop. It then produces a burst of serial clocks whose high and low phases, chip-select lead and chip-select tail are each set by a parameter counted in system clocks. It shifts in one 32-bit frame, MSB first. The frame holds an 8-bit status byte followed by a 24-bit two's-complement result. The block checks the fixed header in the status byte, sign-extends the result and presents it with its channel and flag bits on a valid/ready output. The block does not start a new read while a sample is waiting to be taken.

The same sequencer can send an 8-clock power command. A sleep burst is sent in place of a read when `sleep_req` is high at the moment the ready flag appears. After that burst the block goes dormant and starts no reads. A wake burst is sent while dormant on `wake_req`, without waiting for the ready flag, and reads then resume. A programmable timeout limits the time spent waiting for the ready flag, for example after a wake. The channel-select pin is a registered copy of an input.

The states are IDLE, LEAD, WAIT, LOW, HIGH, TAIL and DONE. The transitions are:
- IDLE→LEAD: a read starts when no sample is pending, or a wake starts while dormant.
- LEAD→WAIT: after the lead time, for a read.
- LEAD→LOW: after the lead time, for a wake.
- WAIT→LOW: the ready flag has been seen.
- WAIT→IDLE: timeout.
- LOW→HIGH: the half period has elapsed.
- HIGH→LOW: the half period has elapsed and bits remain.
- HIGH→TAIL: the last bit is done.
- TAIL→DONE: the tail time has elapsed.
- DONE→IDLE: the frame has been evaluated.

Top module: `adc_serial_host`

## Requirements
- R1: `adc_sclk` is low whenever `adc_csn` is high. `adc_csn` changes only while `adc_sclk` is low. Every high phase and every low phase between bits lasts at least HALF system clocks.
- R2: At least LEAD system clocks pass from the fall of `adc_csn` to the first rise of `adc_sclk`. At least TAIL system clocks pass from the last fall of `adc_sclk` to the rise of `adc_csn`.
- R3: A read waits with `adc_csn` low until `adc_miso` is low. It then gives exactly 32 rising edges of `adc_sclk` and samples `adc_miso` at each rise, with the first bit sampled becoming frame bit 31.
- R4: Frame bits 31..27 must equal 01111. Any other value gives a one-cycle `frame_err` pulse and no sample is presented.
- R5: A good frame presents `smp_data` as frame bits 23..0 sign-extended to 32 bits, `smp_chan` = bit 26, `smp_suspect` = bit 25 (oscillation flag, sample marked untrustworthy) and `smp_over` = bit 24.
- R6: `smp_valid` stays high with `smp_data` stable until `smp_ready` is sampled high, then drops. No chip-select activity begins while a sample is pending.
- R7: If `sleep_req` is high when the ready flag is seen, exactly 8 serial clocks are sent instead of a read. After that the block starts no further transfers until woken.
- R8: While dormant, `wake_req` starts an 8-clock burst without waiting for the ready flag. Normal reads resume afterwards.
- R9: If `adc_miso` stays high for `to_limit` system clocks in the wait state, `timeout_err` pulses for one cycle and chip select is released. A `to_limit` of 0 disables the timeout.
- R10: `adc_chs` follows `chan_req` one clock later.
- R11: In reset, `adc_csn` = 1, `adc_sclk` = 0, `adc_chs` = 0 and `smp_valid`, `frame_err` and `timeout_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | 1 | Requested converter channel |
| sleep_req | input | 1 | Send a sleep burst at the next ready flag |
| wake_req | input | 1 | Send a wake burst while dormant |
| to_limit | input | TO_W | Ready-wait timeout in system clocks, 0 = off |
| adc_miso | input | 1 | Converter data out, low = ready |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_csn | output | 1 | Active-low chip select |
| adc_chs | output | 1 | Channel-select pin |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sample accepted by consumer |
| smp_data | output | OUT_W | Sign-extended result |
| smp_chan | output | 1 | Channel the sample came from |
| smp_over | output | 1 | Overrange flag |
| smp_suspect | output | 1 | Oscillation flag, result not trustworthy |
| frame_err | output | 1 | Header mismatch pulse |
| timeout_err | output | 1 | Ready-wait timeout pulse |

## Verification
The bench goes after the ends of the result range and sign bit 23. A reader that zero-extends or shifts by one bit returns 00800000 or a halved value for 800000. The bench sweeps every header nibble except the valid one. A checker that tests fewer than five bits lets a broken frame through as a valid sample. It also covers the 8-clock sleep and wake bursts: a sequencer with a single burst length sends 32 clocks, and a wake that waits for the ready flag times out and never wakes the converter. The timeout delay is measured against `to_limit`, and a zero limit must never fire. Under back-pressure, any early chip-select activity or data change while a sample is pending is reported.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_WAIT,
        S_LOW,
        S_HIGH,
        S_TAIL,
        S_DONE
    } host_state_t;

    typedef enum logic [1:0] {
        K_READ,
        K_SLEEP,
        K_WAKE
    } burst_kind_t;

    localparam int STATUS_W = 8;
    localparam int HDR_W    = 5;
    localparam logic [HDR_W-1:0] HDR_PAT = 5'b01111;
endpackage

// File: rtl/adc_word_unpack.sv
module adc_word_unpack
    import adc_host_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int OUT_W = 32,
    localparam int FR_W = SMP_W + STATUS_W
) (
    input  logic [FR_W-1:0]  frame,
    output logic             hdr_ok,
    output logic             chan,
    output logic             osc,
    output logic             over,
    output logic [OUT_W-1:0] value
);
    assign hdr_ok = (frame[FR_W-1 -: HDR_W] == HDR_PAT);
    assign chan   = frame[SMP_W+2];
    assign osc    = frame[SMP_W+1];
    assign over   = frame[SMP_W];
    assign value  = {{(OUT_W-SMP_W){frame[SMP_W-1]}}, frame[SMP_W-1:0]};
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int HALF  = 50,
    parameter int LEAD  = 10,
    parameter int TAIL  = 20,
    parameter int TO_W  = 24,
    parameter int SMP_W = 24,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_req,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic [TO_W-1:0]  to_limit,
    input  logic             adc_miso,
    output logic             adc_sclk,
    output logic             adc_csn,
    output logic             adc_chs,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic [OUT_W-1:0] smp_data,
    output logic             smp_chan,
    output logic             smp_over,
    output logic             smp_suspect,
    output logic             frame_err,
    output logic             timeout_err
);
    localparam int FR_W = SMP_W + STATUS_W;
    localparam int BW   = $clog2(FR_W);
    localparam int MAXP = (HALF > LEAD) ? ((HALF > TAIL) ? HALF : TAIL)
                                        : ((LEAD > TAIL) ? LEAD : TAIL);
    localparam int CW   = $clog2(MAXP + 1);
    localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
    localparam logic [CW-1:0] LEAD_END = CW'(LEAD - 1);
    localparam logic [CW-1:0] TAIL_END = CW'(TAIL - 1);

    host_state_t     state, state_nx;
    burst_kind_t     kind;
    logic [CW-1:0]   cnt;
    logic [TO_W-1:0] tocnt;
    logic [BW-1:0]   bitcnt, last_bit;
    logic [FR_W-1:0] shreg;
    logic            miso_m, miso_s, dozing, to_hit;
    logic            u_hdr_ok, u_chan, u_osc, u_over;
    logic [OUT_W-1:0] u_value;

    assign last_bit = (kind == K_READ) ? BW'(FR_W - 1) : BW'(STATUS_W - 1);
    assign to_hit   = (to_limit != '0) && (tocnt == to_limit - TO_W'(1));

    adc_word_unpack #(.SMP_W(SMP_W), .OUT_W(OUT_W)) u_unpack (
        .frame (shreg),
        .hdr_ok(u_hdr_ok),
        .chan  (u_chan),
        .osc   (u_osc),
        .over  (u_over),
        .value (u_value)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (dozing) begin
                    if (wake_req) state_nx = S_LEAD;
                end else if (!smp_valid) begin
                    state_nx = S_LEAD;
                end
            end
            S_LEAD: if (cnt == LEAD_END) state_nx = (kind == K_WAKE) ? S_LOW : S_WAIT;
            S_WAIT: begin
                if (!miso_s)     state_nx = S_LOW;
                else if (to_hit) state_nx = S_IDLE;
            end
            S_LOW:  if (cnt == HALF_END) state_nx = S_HIGH;
            S_HIGH: if (cnt == HALF_END) state_nx = (bitcnt == last_bit) ? S_TAIL : S_LOW;
            S_TAIL: if (cnt == TAIL_END) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // pin outputs, registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_csn  <= 1'b1;
            adc_sclk <= 1'b0;
            adc_chs  <= 1'b0;
        end else begin
            adc_csn  <= !(state_nx inside {S_LEAD, S_WAIT, S_LOW, S_HIGH, S_TAIL});
            adc_sclk <= (state_nx == S_HIGH);
            adc_chs  <= chan_req;
        end
    end

    // datapath: timers, shifter, result and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_m      <= 1'b1;
            miso_s      <= 1'b1;
            cnt         <= '0;
            tocnt       <= '0;
            bitcnt      <= '0;
            shreg       <= '0;
            kind        <= K_READ;
            dozing      <= 1'b0;
            smp_valid   <= 1'b0;
            smp_data    <= '0;
            smp_chan    <= 1'b0;
            smp_over    <= 1'b0;
            smp_suspect <= 1'b0;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            miso_m      <= adc_miso;
            miso_s      <= miso_m;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
            cnt   <= (state_nx != state) ? '0 : cnt + CW'(1);
            tocnt <= (state == S_WAIT) ? tocnt + TO_W'(1) : '0;
            if (smp_valid && smp_ready) smp_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (state_nx == S_LEAD) kind <= dozing ? K_WAKE : K_READ;
                S_LEAD: bitcnt <= '0;
                S_WAIT: begin
                    if (!miso_s && sleep_req) kind <= K_SLEEP;
                    if (miso_s && to_hit)     timeout_err <= 1'b1;
                end
                S_LOW:  if (cnt == HALF_END) shreg <= {shreg[FR_W-2:0], miso_s};
                S_HIGH: if (cnt == HALF_END) bitcnt <= bitcnt + BW'(1);
                S_TAIL: ;
                S_DONE: begin
                    unique case (kind)
                        K_READ: begin
                            if (u_hdr_ok) begin
                                smp_valid   <= 1'b1;
                                smp_data    <= u_value;
                                smp_chan    <= u_chan;
                                smp_over    <= u_over;
                                smp_suspect <= u_osc;
                            end else begin
                                frame_err <= 1'b1;
                            end
                        end
                        K_SLEEP: dozing <= 1'b1;
                        K_WAKE:  dozing <= 1'b0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // checker: length of the current high phase
    logic [CW:0] hi_len;
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_len <= '0;
        else if (adc_sclk) hi_len <= hi_len + (CW+1)'(1);
        else               hi_len <= '0;
    end

    a_r1_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        adc_csn |-> !adc_sclk);
    a_r1_cs_moves_with_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_csn != $past(adc_csn)) |-> (!adc_sclk && !$past(adc_sclk)));
    a_r1_high_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> (hi_len >= (CW+1)'(HALF)));
    a_r6_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
    a_r4_bad_header_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !smp_valid);
    a_r9_timeout_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> adc_csn);
endmodule

// File: tb/adc_serial_host_test.sv
`timescale 1ns/1ps
module adc_serial_host_test;
    localparam int HALF_B = 4;
    localparam int LEAD_B = 3;
    localparam int TAIL_B = 5;
    localparam int TOW_B  = 16;
    localparam int PER    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, smp_ready = 1'b0;
    logic [TOW_B-1:0] to_limit = 16'd40;
    logic adc_miso, adc_sclk, adc_csn, adc_chs;
    logic smp_valid, smp_chan, smp_over, smp_suspect, frame_err, timeout_err;
    logic [31:0] smp_data;

    always #2.5 clk = ~clk;

    adc_serial_host #(.HALF(HALF_B), .LEAD(LEAD_B), .TAIL(TAIL_B), .TO_W(TOW_B)) uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .sleep_req(sleep_req),
        .wake_req(wake_req), .to_limit(to_limit), .adc_miso(adc_miso),
        .adc_sclk(adc_sclk), .adc_csn(adc_csn), .adc_chs(adc_chs),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .smp_chan(smp_chan), .smp_over(smp_over), .smp_suspect(smp_suspect),
        .frame_err(frame_err), .timeout_err(timeout_err)
    );

    // converter model: ready flag then MSB-first bits, next bit after each falling edge
    logic armed = 1'b0;
    int idx = 0;
    logic [31:0] word = '0;
    assign adc_miso = (armed && !adc_csn && idx < 32) ? word[31-idx] : 1'b1;
    always @(negedge adc_sclk) if (armed && !adc_csn) idx <= idx + 1;

    // link timing monitor
    int rises = 0, last_rises = 0, cs_falls = 0, to_count = 0;
    time t_cs = 0, t_rise = 0, t_fall = 0, lead_t = 0, tail_t = 0;
    time min_hi = '1, min_lo = '1;
    always @(negedge adc_csn) begin
        rises = 0; t_cs = $time; min_hi = '1; min_lo = '1; cs_falls++;
    end
    always @(posedge adc_sclk) begin
        if (rises == 0) lead_t = $time - t_cs;
        else if ($time - t_fall < min_lo) min_lo = $time - t_fall;
        t_rise = $time;
        rises++;
    end
    always @(negedge adc_sclk) begin
        if ($time - t_rise < min_hi) min_hi = $time - t_rise;
        t_fall = $time;
    end
    always @(posedge adc_csn) begin
        last_rises = rises;
        tail_t = $time - t_fall;
    end
    always @(posedge clk) if (rst_n && timeout_err) to_count++;

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic timing_checks(input int nrise);
        chk(last_rises == nrise, "R3/R7 serial clock count", last_rises, nrise);
        chk(lead_t >= time'(LEAD_B*PER), "R2 cs lead", lead_t, LEAD_B*PER);
        chk(tail_t >= time'(TAIL_B*PER), "R2 cs tail", tail_t, TAIL_B*PER);
        chk(min_hi >= time'(HALF_B*PER), "R1 high phase", min_hi, HALF_B*PER);
        chk(min_lo >= time'(HALF_B*PER), "R1 low phase", min_lo, HALF_B*PER);
    endtask

    task automatic run_read(input logic [31:0] w, input int hold);
        logic [31:0] expd;
        int falls0;
        @(negedge clk);
        word = w; idx = 0; armed = 1'b1;
        @(posedge adc_csn);
        armed = 1'b0;
        @(negedge clk);
        @(negedge clk);
        timing_checks(32);
        if (w[31:27] == 5'b01111) begin
            expd = {{8{w[23]}}, w[23:0]};
            chk(smp_valid == 1'b1, "R6 valid after read", smp_valid, 1);
            chk(frame_err == 1'b0, "R4 no frame error", frame_err, 0);
            chk(smp_data == expd, "R5 sign-extended data", smp_data, expd);
            chk(smp_chan == w[26], "R5 channel bit", smp_chan, w[26]);
            chk(smp_suspect == w[25], "R5 oscillation bit", smp_suspect, w[25]);
            chk(smp_over == w[24], "R5 overrange bit", smp_over, w[24]);
            if (hold > 0) begin
                falls0 = cs_falls;
                repeat (hold) @(negedge clk);
                chk(smp_valid == 1'b1, "R6 valid held", smp_valid, 1);
                chk(smp_data == expd, "R6 data stable", smp_data, expd);
                chk(cs_falls == falls0, "R6 no transfer while pending", cs_falls, falls0);
            end
            smp_ready = 1'b1;
            @(negedge clk);
            smp_ready = 1'b0;
            chk(smp_valid == 1'b0, "R6 valid drops on accept", smp_valid, 0);
        end else begin
            chk(frame_err == 1'b1, "R4 frame error pulse", frame_err, 1);
            chk(smp_valid == 1'b0, "R4 sample discarded", smp_valid, 0);
        end
    endtask

    initial begin
        logic [23:0] corners [7];
        int n, t0, f0;
        corners[0] = 24'h000000; corners[1] = 24'h7FFFFF; corners[2] = 24'h800000;
        corners[3] = 24'hFFFFFF; corners[4] = 24'h000001; corners[5] = 24'h555555;
        corners[6] = 24'hAAAAAA;

        // R11 reset state
        repeat (4) @(negedge clk);
        chk(adc_csn == 1'b1, "R11 csn in reset", adc_csn, 1);
        chk(adc_sclk == 1'b0, "R11 sclk in reset", adc_sclk, 0);
        chk(adc_chs == 1'b0, "R11 chs in reset", adc_chs, 0);
        chk(smp_valid == 1'b0, "R11 valid in reset", smp_valid, 0);
        chk(frame_err == 1'b0 && timeout_err == 1'b0, "R11 error flags in reset",
            {frame_err, timeout_err}, 0);
        rst_n = 1'b1;

        // R9 timeout with limit 40, converter never ready
        @(negedge adc_csn);
        n = 0;
        do begin @(negedge clk); n++; end while (!timeout_err && n < 500);
        chk(n >= 40 && n <= 40 + LEAD_B + 2, "R9 timeout delay", n, 40 + LEAD_B);
        chk(adc_csn == 1'b1, "R9 cs released on timeout", adc_csn, 1);

        // R9 limit 0 disables
        @(negedge clk); to_limit = '0;
        repeat (3) @(negedge clk);
        t0 = to_count;
        repeat (600) @(negedge clk);
        chk(to_count == t0, "R9 zero limit never times out", to_count, t0);
        to_limit = 16'd5000;

        // R10 channel pin
        @(negedge clk); chan_req = 1'b1;
        @(negedge clk);
        chk(adc_chs == 1'b1, "R10 chs follows high", adc_chs, 1);
        chan_req = 1'b0;
        @(negedge clk);
        chk(adc_chs == 1'b0, "R10 chs follows low", adc_chs, 0);

        // R3 R5: corner results under every flag combination
        for (int c = 0; c < 7; c++)
            for (int f = 0; f < 8; f++)
                run_read({5'b01111, f[2:0], corners[c]}, 0);
        // walking one across the result
        for (int b = 0; b < 24; b++)
            run_read({5'b01111, b[2:0], 24'(1) << b}, 0);
        // R6 back-pressure
        run_read({5'b01111, 3'b101, 24'h812345}, 25);
        // R4 every wrong header nibble
        for (int h = 0; h < 15; h++)
            run_read({1'b0, h[3:0], 3'b010, 24'h123456}, 0);
        run_read({5'b01111, 3'b000, 24'h0ABCDE}, 0);

        // R7 sleep burst
        @(negedge clk);
        sleep_req = 1'b1; word = 32'h7A123456; idx = 0; armed = 1'b1;
        @(posedge adc_csn);
        armed = 1'b0;
        @(negedge clk); sleep_req = 1'b0;
        @(negedge clk);
        timing_checks(8);
        chk(smp_valid == 1'b0, "R7 sleep burst yields no sample", smp_valid, 0);
        f0 = cs_falls; t0 = to_count;
        repeat (300) @(negedge clk);
        chk(cs_falls == f0, "R7 dormant: no transfers", cs_falls, f0);
        chk(to_count == t0, "R7 dormant: no timeouts", to_count, t0);

        // R8 wake burst with the ready flag absent
        wake_req = 1'b1;
        @(negedge adc_csn);
        @(negedge clk); wake_req = 1'b0;
        @(posedge adc_csn);
        @(negedge clk);
        chk(last_rises == 8, "R8 wake burst clocks", last_rises, 8);
        run_read({5'b01111, 3'b100, 24'hF00001}, 0);
        run_read({5'b01111, 3'b001, 24'h7FFFFE}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule